// File: doc/BRIEF.md
# Receive Character Queue with Error Reporting

This block buffers received serial characters between a character framer and a host. Each completed character enters a small first-in first-out queue of 8 or 16 slots. It carries its parity-error, framing-error and break flags along with it. A single extra holding stage sits in front of the queue and plays the part of the receive shift register. When the queue is full, one more character can wait there. If a further character arrives while it waits, the waiting one is lost and an overrun flag is raised.

The host sees the oldest character on the data output. It removes that character with a one-cycle read strobe. The error flags can be reported in two ways. In character mode they describe only the character at the head of the queue. In block mode they are the sticky OR of every character that has been at the head since the last error-clear command. A selectable interrupt follows either "data available" or "queue full". An optional flow-control output requests that the far end stop sending when a start bit arrives while the queue is full.

Top module: `rxq_status_buf`

## Requirements
- R1: A character written with `wr_vld` is stored with its three flags. Characters leave in write order, and `rd_data` shows the oldest one.
- R2: `rdy` is high while the queue holds at least one character. `full` is high while all DEPTH slots are occupied.
- R3: The head character changes only on a `rd_pop` strobe. A `rd_pop` on an empty queue has no effect.
- R4: With `blk_mode` low, the status outputs `{st_brk, st_ferr, st_perr}` equal the flags stored with the head character.
- R5: With `blk_mode` high, each status output is the OR of that flag over every character that has been at the head since the last `err_clr`.
- R6: A character completed while the queue is full waits in the holding stage. It enters the queue on the same clock edge as the next pop, so `full` stays high across that pop.
- R7: Suppose a character waits and another one completes before a slot frees. The waiting character is discarded, the new one takes its place, and the queue contents do not change. `ovr` goes high on the edge that sees `start_det` while a character waits and no slot frees.
- R8: `irq` follows `rdy` when `irq_sel` is 0 and follows `full` when `irq_sel` is 1.
- R9: With `flow_en` high, `rts` falls on the edge where `start_det` arrives while the queue is full. It rises again on the edge after `full` goes low. With `flow_en` low, `rts` is high.
- R10: `err_clr` clears the block-mode sticky flags and `ovr` on the next edge, and it takes priority over setting them.
- R11: While `rdy` is low, all three status outputs read 0 in both modes.
- R12: After synchronous reset, the queue is empty and the holding stage is empty. `ovr` is 0, the sticky flags are 0 and `rts` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | 1 | One-cycle strobe: framer completed a character |
| wr_data | input | DW | Completed character |
| wr_perr | input | 1 | Parity error flag of the completed character |
| wr_ferr | input | 1 | Framing error flag of the completed character |
| wr_brk | input | 1 | Break flag of the completed character |
| start_det | input | 1 | One-cycle pulse: valid start bit detected |
| rd_pop | input | 1 | Host read strobe, removes the head character |
| blk_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| irq_sel | input | 1 | Interrupt source: 0 = rdy, 1 = full |
| flow_en | input | 1 | Enables automatic flow control on `rts` |
| err_clr | input | 1 | Error-clear command strobe |
| rd_data | output | DW | Head character |
| rdy | output | 1 | At least one character queued |
| full | output | 1 | All slots occupied |
| st_perr | output | 1 | Reported parity error |
| st_ferr | output | 1 | Reported framing error |
| st_brk | output | 1 | Reported break |
| ovr | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |
| rts | output | 1 | Request-to-send, high = send permitted |

## Verification
The assertions assume that `wr_vld`, `start_det`, `rd_pop` and `err_clr` are single-cycle strobes. They also assume that `start_det` for a character comes before its `wr_vld`, as a framer produces them, and that mode and select inputs change only between strobes. The bench drives every input just after the falling edge and raises each strobe for exactly one cycle. It issues `start_det` and `wr_vld` on separate cycles, in that order. It pops only in states where the expected head is known, except for one deliberate pop on an empty queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Number of per-character flags carried through the queue.
  localparam int FLAG_W = 3;
  // Flag positions inside the flag field of a queue entry.
  localparam int FLG_PERR = 0;
  localparam int FLG_FERR = 1;
  localparam int FLG_BRK  = 2;

  typedef logic [FLAG_W-1:0] rxq_flags_t;
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int EW    = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  // Small array with asynchronous read: maps to distributed RAM.
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int EW    = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [EW-1:0] in_ent,
  input  logic          pop_req,
  input  logic          start_det,
  input  logic          err_clr,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [EW-1:0] ram_wdata,
  output logic [AW-1:0] ram_raddr,
  output logic          q_rdy,
  output logic          q_full,
  output logic          ovr_flag
);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          hold_v_q;
  logic [EW-1:0] hold_q;
  logic          ovr_q;

  logic pop_ok, room, push;

  assign q_full = (cnt_q == FULL_CNT);
  assign q_rdy  = (cnt_q != '0);
  assign pop_ok = pop_req && q_rdy;
  // A slot is usable if one is empty now or one is freed on this edge.
  assign room   = !q_full || pop_ok;
  // The waiting character always has precedence over a fresh one.
  assign push   = room && (hold_v_q || in_vld);

  assign ram_we    = push;
  assign ram_waddr = wp_q;
  assign ram_wdata = hold_v_q ? hold_q : in_ent;
  assign ram_raddr = rp_q;
  assign ovr_flag  = ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (push)   wp_q <= wp_q + 1'b1;
      if (pop_ok) rp_q <= rp_q + 1'b1;
      unique case ({push, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase

      if (hold_v_q) begin
        // Either moves into the queue or is overwritten by a newer one.
        if (in_vld) hold_q <= in_ent;
        if (room)   hold_v_q <= in_vld;
      end else if (in_vld && !room) begin
        hold_q   <= in_ent;
        hold_v_q <= 1'b1;
      end

      if (err_clr)
        ovr_q <= 1'b0;
      else if (start_det && hold_v_q && !room)
        ovr_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rxq_flags_t head_flags,
  input  logic       q_rdy,
  input  logic       blk_mode,
  input  logic       err_clr,
  output rxq_flags_t stat
);
  rxq_flags_t sticky_q;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || err_clr)
        sticky_q[g] <= 1'b0;
      else if (q_rdy)
        sticky_q[g] <= sticky_q[g] | head_flags[g];
    end
    // The current head always counts, so a flag is visible the moment
    // its character reaches the head.
    assign stat[g] = q_rdy && (head_flags[g] || (blk_mode && sticky_q[g]));
  end
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow (
  input  logic clk,
  input  logic rst,
  input  logic flow_en,
  input  logic start_det,
  input  logic q_full,
  output logic rts
);
  logic rts_q;

  always_ff @(posedge clk) begin
    if (rst || !flow_en)
      rts_q <= 1'b1;
    else if (start_det && q_full)
      rts_q <= 1'b0;
    else if (!q_full)
      rts_q <= 1'b1;
  end

  assign rts = rts_q;
endmodule

// File: rtl/rxq_status_buf.sv
module rxq_status_buf
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int EW   = DW + FLAG_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_vld,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  input  logic          start_det,
  input  logic          rd_pop,
  input  logic          blk_mode,
  input  logic          irq_sel,
  input  logic          flow_en,
  input  logic          err_clr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          full,
  output logic          st_perr,
  output logic          st_ferr,
  output logic          st_brk,
  output logic          ovr,
  output logic          irq,
  output logic          rts
);
  rxq_flags_t    in_flags, head_flags, stat;
  logic [EW-1:0] in_ent, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic          ram_we;

  always_comb begin
    in_flags           = '0;
    in_flags[FLG_PERR] = wr_perr;
    in_flags[FLG_FERR] = wr_ferr;
    in_flags[FLG_BRK]  = wr_brk;
  end
  assign in_ent = {in_flags, wr_data};

  rxq_ctrl #(.EW(EW), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (wr_vld),
    .in_ent    (in_ent),
    .pop_req   (rd_pop),
    .start_det (start_det),
    .err_clr   (err_clr),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_raddr (ram_raddr),
    .q_rdy     (rdy),
    .q_full    (full),
    .ovr_flag  (ovr)
  );

  rxq_ram #(.EW(EW), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign rd_data    = ram_rdata[DW-1:0];
  assign head_flags = ram_rdata[EW-1:DW];

  rxq_stat u_stat (
    .clk        (clk),
    .rst        (rst),
    .head_flags (head_flags),
    .q_rdy      (rdy),
    .blk_mode   (blk_mode),
    .err_clr    (err_clr),
    .stat       (stat)
  );

  assign st_perr = stat[FLG_PERR];
  assign st_ferr = stat[FLG_FERR];
  assign st_brk  = stat[FLG_BRK];

  assign irq = irq_sel ? full : rdy;

  rxq_flow u_flow (
    .clk       (clk),
    .rst       (rst),
    .flow_en   (flow_en),
    .start_det (start_det),
    .q_full    (full),
    .rts       (rts)
  );
endmodule

// File: rtl/rxq_status_buf_chk.sv
module rxq_status_buf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_det,
  input logic          rd_pop,
  input logic          irq_sel,
  input logic          flow_en,
  input logic          err_clr,
  input logic [DW-1:0] rd_data,
  input logic          rdy,
  input logic          full,
  input logic          st_perr,
  input logic          st_ferr,
  input logic          st_brk,
  input logic          ovr,
  input logic          irq,
  input logic          rts
);
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    full |-> rdy); // R2

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    rdy && !rd_pop |=> rdy && $stable(rd_data)); // R3

  AST_FULL_KEPT: assert property (@(posedge clk) disable iff (rst)
    full && !rd_pop |=> full); // R6

  AST_IRQ_FULL_SRC: assert property (@(posedge clk) disable iff (rst)
    irq_sel && irq |-> full); // R8

  AST_RTS_DROP: assert property (@(posedge clk) disable iff (rst)
    flow_en && start_det && full |=> !rts); // R9

  AST_RTS_NO_FLOW: assert property (@(posedge clk) disable iff (rst)
    !flow_en |=> rts); // R9

  AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !ovr); // R10

  AST_EMPTY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> !st_perr && !st_ferr && !st_brk); // R11
endmodule

bind rxq_status_buf rxq_status_buf_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_det (start_det),
  .rd_pop    (rd_pop),
  .irq_sel   (irq_sel),
  .flow_en   (flow_en),
  .err_clr   (err_clr),
  .rd_data   (rd_data),
  .rdy       (rdy),
  .full      (full),
  .st_perr   (st_perr),
  .st_ferr   (st_ferr),
  .st_brk    (st_brk),
  .ovr       (ovr),
  .irq       (irq),
  .rts       (rts)
);

// File: tb/rxq_status_buf_bench.sv
module rxq_status_buf_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;
  localparam int NV    = 6;

  // Vector: {brk, ferr, perr, data}; expected status in char mode = flag field.
  localparam logic [10:0] TBL [NV] = '{
    {3'b000, 8'h41}, {3'b001, 8'h52}, {3'b010, 8'h63},
    {3'b100, 8'h00}, {3'b011, 8'h7E}, {3'b000, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_vld = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic [DW-1:0] wr_data = '0;
  logic start_det = 0, rd_pop = 0, blk_mode = 0, irq_sel = 0, flow_en = 0, err_clr = 0;
  logic [DW-1:0] rd_data;
  logic rdy, full, st_perr, st_ferr, st_brk, ovr, irq, rts;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rxq_status_buf #(.DW(DW), .DEPTH(DEPTH)) u_rxq_status_buf (
    .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_data(wr_data),
    .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .start_det(start_det), .rd_pop(rd_pop), .blk_mode(blk_mode),
    .irq_sel(irq_sel), .flow_en(flow_en), .err_clr(err_clr),
    .rd_data(rd_data), .rdy(rdy), .full(full), .st_perr(st_perr),
    .st_ferr(st_ferr), .st_brk(st_brk), .ovr(ovr), .irq(irq), .rts(rts)
  );

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    wr_vld = 0; start_det = 0; rd_pop = 0; err_clr = 0;
  endtask

  task automatic wr(input logic [10:0] e);
    {wr_brk, wr_ferr, wr_perr, wr_data} = e;
    wr_vld = 1;
    tick();
  endtask

  task automatic pop();
    rd_pop = 1;
    tick();
  endtask

  task automatic start();
    start_det = 1;
    tick();
  endtask

  task automatic clr();
    err_clr = 1;
    tick();
  endtask

  function automatic logic [2:0] st();
    return {st_brk, st_ferr, st_perr};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [2:0] acc;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R12 reset state, R11 zero status when empty
    chk("R12 rdy/full/ovr/rts", {rdy, full, ovr, rts}, 4'b0001);
    chk("R11 status empty", st(), 3'b000);

    // Table walk, character mode: R1, R2, R4
    for (int i = 0; i < NV; i++) wr(TBL[i]);
    chk("R2 rdy after writes", {rdy, full}, 2'b10);
    chk("R8 irq follows rdy", irq, 1'b1);
    for (int i = 0; i < NV; i++) begin
      chk($sformatf("R1 data %0d", i), rd_data, TBL[i][7:0]);
      chk($sformatf("R4 flags %0d", i), st(), TBL[i][10:8]);
      pop();
    end
    chk("R2 empty after drain", rdy, 1'b0);
    chk("R11 status zero after drain", st(), 3'b000);

    // R3 pop on empty has no effect
    pop();
    wr({3'b001, 8'h3C});
    chk("R3 head after empty pop", {rdy, rd_data}, {1'b1, 8'h3C});
    tick();
    chk("R3 head held without pop", rd_data, 8'h3C);
    pop();

    // Block mode: R5, R10
    blk_mode = 1;
    clr();
    for (int i = 0; i < NV; i++) wr(TBL[i]);
    acc = 3'b000;
    for (int i = 0; i < NV; i++) begin
      if (i == 3) begin
        clr();
        acc = 3'b000;
      end
      acc |= TBL[i][10:8];
      chk($sformatf("R5 sticky at %0d", i), st(), acc);
      pop();
    end
    chk("R11 block status empty", st(), 3'b000);
    blk_mode = 0;

    // Fill: R2, R8
    irq_sel = 1;
    for (int i = 0; i < DEPTH - 1; i++) wr({3'b000, 8'h40 + 8'(i)});
    chk("R8 irq low when not full", {full, irq}, 2'b00);
    wr({3'b000, 8'h40 + 8'(DEPTH - 1)});
    chk("R8 irq follows full", {full, irq}, 2'b11);

    // Flow control and overrun: R9, R7, R6
    flow_en = 1;
    tick();
    start();
    chk("R9 rts dropped", rts, 1'b0);
    wr({3'b000, 8'hA5});
    chk("R7 no overrun yet", {ovr, full}, 2'b01);
    start();
    chk("R7 overrun on start", ovr, 1'b1);
    wr({3'b000, 8'h5A});
    chk("R6 head unchanged", rd_data, 8'h40);
    pop();
    chk("R6 still full after pop", full, 1'b1);
    chk("R9 rts low while full", rts, 1'b0);
    for (int i = 1; i < DEPTH; i++) begin
      chk($sformatf("R7 order %0d", i), rd_data, 8'h40 + 8'(i));
      pop();
    end
    chk("R9 rts back", rts, 1'b1);
    chk("R7 waiting char survived, lost one gone", rd_data, 8'h5A);
    pop();
    chk("R2 empty", rdy, 1'b0);
    clr();
    chk("R10 overrun cleared", ovr, 1'b0);

    // Flow control off: R9
    flow_en = 0;
    for (int i = 0; i < DEPTH; i++) wr({3'b000, 8'(i)});
    start();
    chk("R9 rts high when disabled", {full, rts}, 2'b11);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R2 drained", rdy, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule